// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Controller

This block sits between a small 8-bit processor core and an external memory or peripheral bus whose low address byte and data byte travel over one shared set of pins. The core raises a request with a write flag, a 16-bit address and a write byte, and holds it until the block pulses done. The block then runs one bus cycle: it drives the full address, pulses an address-latch strobe so an outside latch can grab the low address byte, and turns the shared port over to data. The high address byte has its own pins and stays put for the whole cycle and after it.

The block runs from a clock at twice the bus rate, so each bus period is two block clocks (two half-slots). A plain cycle is two bus periods, T1 and T2, which is four half-slots numbered 0 to 3. When the wait-state input is high at acceptance, a third period T3 adds slots 4 and 5. The active-low write strobe is low for the final half-slot only. The active-low read strobe is low from slot 2 through the final slot, and read data is taken from the shared port at the clock edge that ends that final slot. A free-running bus-clock output marks the bus periods, and every cycle starts at the beginning of one.

Top module: `muxbus_top`

## Requirements
- R1: During and right after synchronous reset, ale is 0, rdN and wrN are 1, adOe is 0, done is 0, addrHi is 0 and busClk is 1.
- R2: ale is 1 in slot 0 only. In slot 0, adOut carries address bits 7..0, addrHi carries address bits 15..8 and adOe is 1.
- R3: addrHi holds the accepted address bits 15..8 from slot 0 through the end of the cycle, and keeps that value while idle until the next cycle is accepted. Changes on addr, wdata or wrEn after acceptance have no effect on the running cycle.
- R4: On a write, adOe is 1 in every slot. adOut holds address bits 7..0 in slot 1, then the write byte from slot 2 to the end. wrN is 0 in the final slot only (half a bus period), and the device stores adOut as wrN rises.
- R5: On a read, adOe is 0 from slot 1 to the end, and rdN is 0 from slot 2 through the final slot: two half-slots (one bus period) without a wait state, four with one. wrN stays 1.
- R6: On a read, rdata takes the value on adIn during the final slot, and holds it while done is 1.
- R7: waitEn sampled at acceptance selects the cycle length: 4 half-slots when 0, 6 when 1.
- R8: done is 1 for exactly one clock, the clock after the final slot. No new cycle starts in that clock, even with req held high. The earliest next slot 0 is three clocks after the final slot.
- R9: busClk toggles every clock and is 1 in every even slot. A request is accepted only so that slot 0 falls where busClk is 1.
- R10: While idle (no cycle running), adOe is 0, rdN and wrN are 1 and ale is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the bus rate |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Core request, held until done |
| wrEn | input | 1 | 1 = write, 0 = read |
| waitEn | input | 1 | Insert one wait-state period (T3) |
| addr | input | 16 | Core address |
| wdata | input | 8 | Core write byte |
| rdata | output | 8 | Read byte returned to the core |
| done | output | 1 | One-clock completion pulse |
| busClk | output | 1 | Reference bus clock, high in the first half of each bus period |
| ale | output | 1 | Address-latch strobe, active high |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| addrHi | output | 8 | Address bits 15..8 |
| adOut | output | 8 | Shared port output value (low address or write byte) |
| adOe | output | 1 | Shared port output enable |
| adIn | input | 8 | Shared port input value |

## Verification
The bench goes after the hand-over points of the shared port. A design that changed the port to data one slot early would fail the write-side latch check at slot 1, and one that kept driving during a read would collide with the device while the read strobe is low. It checks strobe lengths with and without the wait state: a write strobe held for a full period, or a read strobe that ignores T3, shows up as a slot-by-slot mismatch. It also checks that read data is taken in the final slot, since the device drives zero outside the strobe, and that a request still held during done does not start a new cycle early. Address inputs are changed in the middle of cycles to catch a design that reads them live instead of from its capture.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

  localparam int SLOT_W     = 3;
  localparam int LAST_PLAIN = 3;   // T1 + T2 = four half-slots
  localparam int LAST_WAIT  = 5;   // T1 + T2 + T3 = six half-slots
  localparam int DATA_SLOT  = 2;   // first slot of the data phase

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } cycState_e;

  typedef struct packed {
    logic busy;
    logic ale;
    logic oe;
    logic drvData;
    logic rdStb;
    logic wrStb;
    logic sample;
    logic done;
  } busCtl_t;

endpackage

// File: rtl/muxbus_ctrl.sv
module muxbus_ctrl
  import muxbus_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    req,
  input  logic    wrEn,
  input  logic    waitEn,
  output busCtl_t ctl,
  output logic    accept,
  output logic    busClk
);

  cycState_e         st;
  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] lastSlot;
  logic              isWr;
  logic              halfSel;
  logic              inBusy;
  logic              atLast;

  // Accept only in the second half of a bus period, so slot 0 starts a period.
  assign accept = (st == ST_IDLE) && req && halfSel;
  assign inBusy = (st == ST_BUSY);
  assign atLast = inBusy && (slot == lastSlot);

  always_ff @(posedge clk) begin
    if (rst) halfSel <= 1'b0;
    else     halfSel <= ~halfSel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      slot     <= '0;
      lastSlot <= SLOT_W'(LAST_PLAIN);
      isWr     <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            st       <= ST_BUSY;
            slot     <= '0;
            isWr     <= wrEn;
            lastSlot <= waitEn ? SLOT_W'(LAST_WAIT) : SLOT_W'(LAST_PLAIN);
          end
        end
        ST_BUSY: begin
          if (slot == lastSlot) st <= ST_DONE;
          else                  slot <= slot + 1'b1;
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.busy    = inBusy;
    ctl.ale     = inBusy && (slot == '0);
    ctl.oe      = inBusy && (isWr || (slot == '0));
    ctl.drvData = inBusy && isWr && (slot >= SLOT_W'(DATA_SLOT));
    ctl.wrStb   = atLast && isWr;
    ctl.rdStb   = inBusy && !isWr && (slot >= SLOT_W'(DATA_SLOT));
    ctl.sample  = atLast && !isWr;
    ctl.done    = (st == ST_DONE);
  end

  assign busClk = ~halfSel;

  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ctl.ale |=> !ctl.ale);  // R2

  AST_WR_HALF: assert property (@(posedge clk) disable iff (rst)
    ctl.wrStb |=> !ctl.wrStb);  // R4

  AST_RD_RELEASED: assert property (@(posedge clk) disable iff (rst)
    ctl.rdStb |-> !ctl.oe);  // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    ctl.done |=> (!ctl.done && !ctl.busy));  // R8

  AST_ALIGNED_START: assert property (@(posedge clk) disable iff (rst)
    ctl.ale |-> busClk);  // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ctl.busy |-> (!ctl.oe && !ctl.rdStb && !ctl.wrStb && !ctl.ale));  // R10

endmodule

// File: rtl/muxbus_datapath.sv
module muxbus_datapath
  import muxbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 accept,
  input  busCtl_t              ctl,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [DATA_W-1:0]    adIn,
  output logic [DATA_W-1:0]    adOut,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic [DATA_W-1:0]    rdata
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;

  // Address and write byte are captured once, at acceptance.
  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ  <= '0;
      wdataQ <= '0;
    end else if (accept) begin
      addrQ  <= addr;
      wdataQ <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             rdataQ <= '0;
    else if (ctl.sample) rdataQ <= adIn;
  end

  assign adOut  = ctl.drvData ? wdataQ : addrQ[DATA_W-1:0];
  assign addrHi = addrQ[ADDR_W-1:DATA_W];
  assign rdata  = rdataQ;

  AST_HI_STABLE: assert property (@(posedge clk) disable iff (rst)
    (ctl.busy && !ctl.ale) |-> $stable(addrHi));  // R3

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    accept |-> (!ctl.busy && !ctl.done));  // R8

  AST_HI_WIDTH: assert property (@(posedge clk) disable iff (rst)
    ctl.ale |=> (addrHi == $past(addrHi)) || !ctl.busy || (HI_W == 0));  // R3

endmodule

// File: rtl/muxbus_top.sv
module muxbus_top
  import muxbus_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        req,
  input  logic        wrEn,
  input  logic        waitEn,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic        done,
  output logic        busClk,
  output logic        ale,
  output logic        rdN,
  output logic        wrN,
  output logic [7:0]  addrHi,
  output logic [7:0]  adOut,
  output logic        adOe,
  input  logic [7:0]  adIn
);

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  busCtl_t ctl;
  logic    accept;

  muxbus_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .req    (req),
    .wrEn   (wrEn),
    .waitEn (waitEn),
    .ctl    (ctl),
    .accept (accept),
    .busClk (busClk)
  );

  muxbus_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .accept (accept),
    .ctl    (ctl),
    .addr   (addr),
    .wdata  (wdata),
    .adIn   (adIn),
    .adOut  (adOut),
    .addrHi (addrHi),
    .rdata  (rdata)
  );

  assign ale  = ctl.ale;
  assign rdN  = ~ctl.rdStb;
  assign wrN  = ~ctl.wrStb;
  assign adOe = ctl.oe;
  assign done = ctl.done;

  AST_STROBES_APART: assert property (@(posedge clk) disable iff (rst)
    !(!rdN && !wrN));  // R5

endmodule

// File: tb/muxbus_top_tb.sv
module muxbus_top_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        req, wrEn, waitEn;
  logic [15:0] addr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic        done, busClk, ale, rdN, wrN, adOe;
  logic [7:0]  addrHi, adOut, adIn;

  always #4 clk = ~clk;  // 125 MHz

  muxbus_top u_dut (
    .clk(clk), .rst(rst), .req(req), .wrEn(wrEn), .waitEn(waitEn),
    .addr(addr), .wdata(wdata), .rdata(rdata), .done(done),
    .busClk(busClk), .ale(ale), .rdN(rdN), .wrN(wrN),
    .addrHi(addrHi), .adOut(adOut), .adOe(adOe), .adIn(adIn)
  );

  int nChk = 0;
  int nBad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- external device: latch + small byte memory ----------------
  logic [7:0] mem [0:1023];
  logic [7:0] devLo;
  logic       wrPend;
  logic [7:0] wrVal;
  logic [9:0] wrIdx;
  wire  [9:0] devIdx = {addrHi[1:0], devLo};
  assign adIn = !rdN ? mem[devIdx] : 8'h00;

  // ---------------- behavioural reference ----------------
  int          mSt;      // 0 idle, 1 running, 2 done
  int          mSlot, mLen;
  bit          mWr, mHalf;
  logic [15:0] mAddr;
  logic [7:0]  mWd, mExpRd;

  always @(posedge clk) begin
    if (rst) begin
      mSt = 0; mHalf = 0; mAddr = 16'h0; mSlot = 0; mLen = 4; mWr = 0;
    end else begin
      case (mSt)
        0: if (req && mHalf) begin
             mSt = 1; mSlot = 0; mLen = waitEn ? 6 : 4;
             mWr = wrEn; mAddr = addr; mWd = wdata;
           end
        1: if (mSlot == mLen - 1) mSt = 2; else mSlot++;
        default: mSt = 0;
      endcase
      mHalf = !mHalf;
    end
  end

  always @(negedge clk) begin
    bit run;
    bit eAle, eOe, eRdN, eWrN, eDone, eClk;
    run   = (mSt == 1);
    eAle  = run && mSlot == 0;
    eOe   = run && (mWr || mSlot == 0);
    eWrN  = !(run && mWr && mSlot == mLen - 1);
    eRdN  = !(run && !mWr && mSlot >= 2);
    eDone = (mSt == 2);
    eClk  = !mHalf;
    if (rst) begin
      check(ale == 0 && rdN == 1 && wrN == 1 && adOe == 0 && done == 0,
            "R1 reset strobes", {ale, rdN, wrN, adOe, done}, 5'b01100);
      check(addrHi == 0, "R1 reset addrHi", addrHi, 0);
      check(busClk == 1, "R1 reset busClk", busClk, 1);
    end else begin
      check(ale == eAle, run ? "R2 ale" : "R10 ale idle", ale, eAle);
      check(adOe == eOe, run ? (mWr ? "R4 adOe" : "R5 adOe") : "R10 adOe idle", adOe, eOe);
      check(wrN == eWrN, run ? "R4 wrN" : "R10 wrN idle", wrN, eWrN);
      check(rdN == eRdN, run ? "R5 rdN" : "R10 rdN idle", rdN, eRdN);
      check(done == eDone, "R8 done", done, eDone);
      check(busClk == eClk, "R9 busClk", busClk, eClk);
      check(addrHi == mAddr[15:8], "R3 addrHi", addrHi, mAddr[15:8]);
      if (run && mSlot <= 1)
        check(adOut == mAddr[7:0], "R2 low address on port", adOut, mAddr[7:0]);
      if (run && mWr && mSlot >= 2)
        check(adOut == mWd, "R4 write byte on port", adOut, mWd);
      if (eAle)
        check(busClk == 1, "R9 slot 0 aligned", busClk, 1);
      if (run && !mWr && mSlot == mLen - 1)
        mExpRd = mem[{mAddr[9:8], mAddr[7:0]}];
      if (eDone && !mWr)
        check(rdata == mExpRd, "R6 rdata", rdata, mExpRd);
    end
    // device side
    if (ale) devLo = adOut;
    if (!wrN) begin wrPend = 1; wrVal = adOut; wrIdx = devIdx; end
    else if (wrPend) begin mem[wrIdx] = wrVal; wrPend = 0; end
  end

  // ---------------- stimulus ----------------
  task automatic runCycle(input bit w, input logic [15:0] a, input logic [7:0] d,
                          input bit ws, input bit scramble, output logic [7:0] got);
    int n = 0;
    @(negedge clk);
    req = 1; wrEn = w; addr = a; wdata = d; waitEn = ws;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
      if (scramble && n == 3) begin  // R3: inputs changed mid-cycle are ignored
        addr = ~a; wdata = ~d; wrEn = !w; waitEn = !ws;
      end
    end
    if (n >= 100) check(0, "R8 done timeout", 0, 1);
    got = rdata;
    // keep req high through the done clock, dropped afterwards (R8)
    @(negedge clk);
    check(done == 0, "R8 done single pulse", done, 0);
    check(ale == 0, "R8 no start during done", ale, 0);
    req = 0;
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        nChk++; nBad++;
        $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] got;
    int rdStart, rdLen;
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
    wrPend = 0; devLo = 0;
    rst = 1; req = 0; wrEn = 0; waitEn = 0; addr = 0; wdata = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);

    // plain write, then wait-state write
    runCycle(1, 16'h1234, 8'hA5, 0, 0, got);
    runCycle(1, 16'h82F0, 8'h3C, 1, 0, got);
    repeat (2) @(negedge clk);
    check(mem[{2'b10, 8'h34}] == 8'hA5, "R4 device stored plain write", mem[{2'b10, 8'h34}], 8'hA5);
    check(mem[{2'b10, 8'hF0}] == 8'h3C, "R4 device stored wait write", mem[{2'b10, 8'hF0}], 8'h3C);
    check(addrHi == 8'h82, "R3 addrHi held while idle", addrHi, 8'h82);

    // read back with and without the wait state
    runCycle(0, 16'h1234, 8'h00, 0, 0, got);
    check(got == 8'hA5, "R6 plain read returns written byte", got, 8'hA5);
    runCycle(0, 16'h82F0, 8'h00, 1, 0, got);
    check(got == 8'h3C, "R7 wait read returns written byte", got, 8'h3C);

    // measure read strobe length directly (R5, R7)
    for (int ws = 0; ws < 2; ws++) begin
      fork
        runCycle(0, 16'h0155, 8'h00, ws[0], 0, got);
        begin
          rdLen = 0;
          @(negedge clk);
          while (!done) begin
            if (!rdN) rdLen++;
            @(negedge clk);
          end
        end
      join
      check(rdLen == (ws ? 4 : 2), ws ? "R7 read strobe with T3" : "R5 read strobe plain",
            rdLen, ws ? 4 : 2);
    end

    // inputs scrambled mid-cycle
    runCycle(1, 16'h3377, 8'h5A, 0, 1, got);
    runCycle(0, 16'h3377, 8'h00, 1, 1, got);
    check(got == 8'h5A, "R3 scrambled inputs ignored", got, 8'h5A);

    // patterned sweep over several addresses and both lengths
    for (int k = 0; k < 12; k++) begin
      logic [15:0] a;
      logic [7:0]  d;
      a = 16'((k * 16'h1357) ^ 16'h0A0A);
      d = 8'(k * 29 + 1);
      runCycle(1, a, d, k[0], 0, got);
      runCycle(0, a, 8'h00, k[1], 0, got);
      check(got == d, "R6 sweep read-back", got, d);
    end

    rdStart = 0;
    repeat (4) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule